// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

The block holds a small set-associative table of page translations and turns a 32-bit virtual address into a 4 KiB-aligned physical page address plus read, write, execute and cacheable attributes. A lookup presents the virtual address, an access kind and the current process identifier (PID). The page number (address bits 31:12) selects one set from its low bits. Every way of that set is compared in parallel, and the registered answer appears one clock later. The answer also states whether the requested kind of access is permitted.

Table contents are managed through a simple write port, which stores a tag word and a data word at a chosen way and set, and a read port, which returns both words one clock later. The tag word has a fixed layout. The page number sits in bits 31:12, the global flag in bit 11 and the valid flag in bit 10, and the PID occupies the low PID-width bits. Reset empties the table.

Top module: `tlb_xlate_unit`

## Requirements
- R1: A lookup sampled with `lk_req` high at a clock edge produces `rsp_valid` high after that edge, for one cycle per request. A cycle without `lk_req` gives `rsp_valid` low and all other `rsp_*` outputs zero.
- R2: The set probed is page-number bits [SET_W-1:0], that is, address bits [12+SET_W-1:12], where SET_W = log2(ENTRIES/WAYS). All WAYS ways of that set are examined, and entries in other sets never match.
- R3: An entry matches only when tag bit 10 (valid) is 1, tag bits 31:12 equal address bits 31:12, and either tag bit 11 (global) is 1 or tag bits [PID_W-1:0] equal `lk_pid`.
- R4: On a hit, `rsp_paddr` is data bits 19:0 shifted left by 12, with the low 12 bits zero. `rsp_rd`, `rsp_wr`, `rsp_ex` and `rsp_cache` equal data bits 22, 21, 20 and 23 respectively.
- R5: When no way matches, `rsp_hit`, `rsp_paddr`, `rsp_way`, all attribute outputs and `rsp_allow` are zero.
- R6: When several ways match, the lowest-numbered matching way supplies the result, and its number appears on `rsp_way`.
- R7: `rsp_allow` is high only on a hit whose attribute permits the access kind. Kind 0 (load) needs the read bit, kind 1 (store) needs the write bit and kind 2 (fetch) needs the execute bit. Kind 3 is never allowed.
- R8: `wr_en` stores `wr_tag` and `wr_data` at (`wr_way`, `wr_set`) on that clock edge. A lookup sampled at the same edge still sees the old contents, and lookups from the next cycle see the new ones.
- R9: With `rd_en` high at an edge, `rd_valid`, `rd_tag` and `rd_data` show the 32-bit words stored at (`rd_way`, `rd_set`) after that edge, taken before any write at the same edge. Without `rd_en` these outputs are zero.
- R10: Reset (synchronous, `rst_n` low) clears every tag and data word, so every lookup misses and every readback returns zero until entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_pid | input | PID_W | Current process identifier |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A way matched |
| rsp_way | output | WAY_W | Number of the matching way |
| rsp_paddr | output | 32 | Physical page address |
| rsp_rd | output | 1 | Read permitted by entry |
| rsp_wr | output | 1 | Write permitted by entry |
| rsp_ex | output | 1 | Execute permitted by entry |
| rsp_cache | output | 1 | Page is cacheable |
| rsp_allow | output | 1 | Requested access kind permitted |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | WAY_W | Way to write |
| wr_set | input | SET_W | Set to write |
| wr_tag | input | 32 | Tag word to store |
| wr_data | input | 32 | Data word to store |
| rd_en | input | 1 | Entry read strobe |
| rd_way | input | WAY_W | Way to read |
| rd_set | input | SET_W | Set to read |
| rd_valid | output | 1 | Readback valid |
| rd_tag | output | 32 | Stored tag word |
| rd_data | output | 32 | Stored data word |

## Verification
The bench targets entries that carry the right page number in the wrong set, a PID mismatch masked by the global flag, and an entry with the valid flag cleared. A design that mis-slices the index or ignores either flag would report hits where misses are due. Identical tags in two ways check that the lower way wins; a reversed priority encoder would return the other way's frame number and way index. A write and a lookup of the same entry in one cycle must miss and then hit on the next request, which exposes write-through forwarding. Each access kind is tried against single-permission entries so that a swapped attribute bit shows up on `rsp_allow`.

// File: rtl/tlb_pkg.sv
// Package tlb_pkg
// Shared field positions and the access-kind type of the translation buffer.
// Assumes 32-bit addresses and 4 KiB pages.
package tlb_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN_W      = 32 - PAGE_SHIFT;
    localparam int PFN_W      = 20;
    localparam int TAG_G_BIT  = 11;
    localparam int TAG_V_BIT  = 10;
    localparam int DAT_X_BIT  = 20;
    localparam int DAT_W_BIT  = 21;
    localparam int DAT_R_BIT  = 22;
    localparam int DAT_C_BIT  = 23;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic                 hit;
        logic [31:0]          paddr;
        logic                 rd;
        logic                 wr;
        logic                 ex;
        logic                 cache;
        logic                 allow;
    } xlate_t;

    // Page-number field of a tag word.
    function automatic logic [VPN_W-1:0] tag_vpn(input logic [31:0] t);
        return t[31:PAGE_SHIFT];
    endfunction
endpackage

// File: rtl/tlb_store.sv
// Module tlb_store
// Holds the tag and data words of every entry, one bank per way.
// Provides a combinational read of all ways of one set for lookup, a
// combinational read of one entry for the readback port, and a single
// synchronous write. Reads return the contents before a same-edge write.
// Assumes WAYS and SETS are powers of two, both at least 2.
module tlb_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int WAY_W = 2,
    parameter int SET_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [WAY_W-1:0]       wr_way,
    input  logic [SET_W-1:0]       wr_set,
    input  logic [31:0]            wr_tag,
    input  logic [31:0]            wr_data,
    input  logic [SET_W-1:0]       lk_set,
    output logic [WAYS-1:0][31:0]  set_tags,
    output logic [WAYS-1:0][31:0]  set_data,
    input  logic [WAY_W-1:0]       rd_way,
    input  logic [SET_W-1:0]       rd_set,
    output logic [31:0]            rd_tag_c,
    output logic [31:0]            rd_data_c
);
    logic [WAYS-1:0][31:0] way_rd_tag;
    logic [WAYS-1:0][31:0] way_rd_data;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [31:0] tag_mem  [SETS];
        logic [31:0] data_mem [SETS];
        logic        bank_we;

        // Select this bank for the incoming write.
        assign bank_we = wr_en && (wr_way == WAY_W'(w));

        // Clear the bank on reset, otherwise accept the write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    tag_mem[s]  <= '0;
                    data_mem[s] <= '0;
                end
            end else if (bank_we) begin
                tag_mem[wr_set]  <= wr_tag;
                data_mem[wr_set] <= wr_data;
            end
        end

        assign set_tags[w]    = tag_mem[lk_set];
        assign set_data[w]    = data_mem[lk_set];
        assign way_rd_tag[w]  = tag_mem[rd_set];
        assign way_rd_data[w] = data_mem[rd_set];
    end

    assign rd_tag_c  = way_rd_tag[rd_way];
    assign rd_data_c = way_rd_data[rd_way];
endmodule

// File: rtl/tlb_way_cmp.sv
// Module tlb_way_cmp
// Decides whether one stored tag word matches a request: valid flag set,
// page numbers equal, and either the global flag set or the PIDs equal.
// Purely combinational; assumes the fixed tag layout of tlb_pkg.
module tlb_way_cmp
    import tlb_pkg::*;
#(
    parameter int PID_W = 8
) (
    input  logic [31:0]       tag,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [PID_W-1:0]  req_pid,
    output logic              match
);
    logic vpn_eq;
    logic pid_ok;

    // Compare the page number and the owner of the entry.
    always_comb begin
        vpn_eq = (tag_vpn(tag) == req_vpn);
        pid_ok = tag[TAG_G_BIT] || (tag[PID_W-1:0] == req_pid);
        match  = tag[TAG_V_BIT] && vpn_eq && pid_ok;
    end
endmodule

// File: rtl/tlb_pick.sv
// Module tlb_pick
// Priority selector: grants the lowest-numbered asserted match bit and
// reports its index. Purely combinational; WAYS is at least 2.
module tlb_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  match,
    output logic [WAYS-1:0]  grant,
    output logic [WAY_W-1:0] idx,
    output logic             any
);
    // Scan from the highest way down so the lowest match is kept.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                grant = '0;
                grant[w] = 1'b1;
                idx = WAY_W'(w);
            end
        end
        any = |match;
    end

    // R6: at most one way granted, and only a matching one.
    always_comb begin
        a_r6_grant_onehot: assert ($onehot0(grant));
        a_r6_grant_in_match: assert ((grant & ~match) == '0);
    end
endmodule

// File: rtl/tlb_xlate_unit.sv
// Module tlb_xlate_unit
// Set-associative translation buffer. A lookup is sampled on a clock edge;
// the set is taken from the low page-number bits, all ways are compared,
// the lowest matching way is chosen and the registered result appears the
// next cycle. Write and readback ports manage entries by way and set.
// Assumes WAYS and ENTRIES/WAYS are powers of two, each at least 2.
module tlb_xlate_unit
    import tlb_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int ENTRIES = 64,
    parameter int PID_W   = 8,
    localparam int SETS   = ENTRIES / WAYS,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [31:0]       lk_vaddr,
    input  logic [1:0]        lk_acc,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic              rsp_ex,
    output logic              rsp_cache,
    output logic              rsp_allow,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [31:0]       wr_tag,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [SET_W-1:0]  rd_set,
    output logic              rd_valid,
    output logic [31:0]       rd_tag,
    output logic [31:0]       rd_data
);
    logic [VPN_W-1:0]       req_vpn;
    logic [SET_W-1:0]       req_set;
    logic [WAYS-1:0][31:0]  set_tags;
    logic [WAYS-1:0][31:0]  set_data;
    logic [31:0]            rd_tag_c;
    logic [31:0]            rd_data_c;
    logic [WAYS-1:0]        match;
    logic [WAYS-1:0]        grant;
    logic [WAY_W-1:0]       hit_idx;
    logic                   hit_any;
    logic [31:0]            sel_data;
    xlate_t                 nxt;
    acc_e                   acc;

    // Split the request address into page number and set index.
    always_comb begin
        req_vpn = lk_vaddr[31:PAGE_SHIFT];
        req_set = lk_vaddr[PAGE_SHIFT +: SET_W];
        acc     = acc_e'(lk_acc);
    end

    tlb_store #(
        .WAYS (WAYS),
        .SETS (SETS),
        .WAY_W(WAY_W),
        .SET_W(SET_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_way   (wr_way),
        .wr_set   (wr_set),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .lk_set   (req_set),
        .set_tags (set_tags),
        .set_data (set_data),
        .rd_way   (rd_way),
        .rd_set   (rd_set),
        .rd_tag_c (rd_tag_c),
        .rd_data_c(rd_data_c)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        tlb_way_cmp #(.PID_W(PID_W)) u_cmp (
            .tag    (set_tags[w]),
            .req_vpn(req_vpn),
            .req_pid(lk_pid),
            .match  (match[w])
        );
    end

    tlb_pick #(
        .WAYS (WAYS),
        .WAY_W(WAY_W)
    ) u_pick (
        .match(match),
        .grant(grant),
        .idx  (hit_idx),
        .any  (hit_any)
    );

    // Form the next result from the granted way's data word.
    always_comb begin
        sel_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (grant[w]) sel_data = sel_data | set_data[w];
        end
        nxt       = '0;
        nxt.hit   = hit_any;
        nxt.paddr = {sel_data[PFN_W-1:0], {PAGE_SHIFT{1'b0}}};
        nxt.rd    = sel_data[DAT_R_BIT];
        nxt.wr    = sel_data[DAT_W_BIT];
        nxt.ex    = sel_data[DAT_X_BIT];
        nxt.cache = sel_data[DAT_C_BIT];
        unique case (acc)
            ACC_LOAD:  nxt.allow = hit_any && sel_data[DAT_R_BIT];
            ACC_STORE: nxt.allow = hit_any && sel_data[DAT_W_BIT];
            ACC_FETCH: nxt.allow = hit_any && sel_data[DAT_X_BIT];
            default:   nxt.allow = 1'b0;
        endcase
    end

    // Register the lookup result; zero when idle or missing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_paddr <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
            rsp_cache <= 1'b0;
            rsp_allow <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && nxt.hit;
            rsp_way   <= (lk_req && nxt.hit) ? hit_idx : '0;
            rsp_paddr <= (lk_req && nxt.hit) ? nxt.paddr : '0;
            rsp_rd    <= lk_req && nxt.hit && nxt.rd;
            rsp_wr    <= lk_req && nxt.hit && nxt.wr;
            rsp_ex    <= lk_req && nxt.hit && nxt.ex;
            rsp_cache <= lk_req && nxt.hit && nxt.cache;
            rsp_allow <= lk_req && nxt.allow;
        end
    end

    // Register the readback words; zero when not requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_tag   <= rd_en ? rd_tag_c  : '0;
            rd_data  <= rd_en ? rd_data_c : '0;
        end
    end

    // R1: one response cycle per request cycle.
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    a_r1_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    // R4: the physical address is page aligned.
    a_r4_paddr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_paddr[PAGE_SHIFT-1:0] == '0);
    // R5: a miss carries no translation.
    a_r5_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex && !rsp_cache && rsp_way == '0));
    // R7: permission only with a hit.
    a_r7_allow_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_hit && rsp_valid));
    // R9: readback answers the cycle after the strobe.
    a_r9_rd_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: tb/tlb_xlate_unit_bench.sv
`timescale 1ns/1ps
module tlb_xlate_unit_bench;
    localparam int WAYS    = 4;
    localparam int ENTRIES = 64;
    localparam int PID_W   = 8;
    localparam int SETS    = ENTRIES / WAYS;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int SET_W   = $clog2(SETS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0] lk_acc = '0;
    logic [PID_W-1:0] lk_pid = '0;
    logic rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_cache, rsp_allow;
    logic [WAY_W-1:0] rsp_way;
    logic [31:0] rsp_paddr;
    logic wr_en = 1'b0;
    logic [WAY_W-1:0] wr_way = '0;
    logic [SET_W-1:0] wr_set = '0;
    logic [31:0] wr_tag = '0, wr_data = '0;
    logic rd_en = 1'b0;
    logic [WAY_W-1:0] rd_way = '0;
    logic [SET_W-1:0] rd_set = '0;
    logic rd_valid;
    logic [31:0] rd_tag, rd_data;

    always #5 clk = ~clk;

    tlb_xlate_unit #(.WAYS(WAYS), .ENTRIES(ENTRIES), .PID_W(PID_W)) u_tlb_xlate_unit (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_acc(lk_acc), .lk_pid(lk_pid), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_paddr(rsp_paddr),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
        .rsp_cache(rsp_cache), .rsp_allow(rsp_allow), .wr_en(wr_en),
        .wr_way(wr_way), .wr_set(wr_set), .wr_tag(wr_tag), .wr_data(wr_data),
        .rd_en(rd_en), .rd_way(rd_way), .rd_set(rd_set), .rd_valid(rd_valid),
        .rd_tag(rd_tag), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit armed = 0;
    string phase = "R10";

    // Reference table and expected outputs.
    logic [31:0] m_tag  [WAYS][SETS];
    logic [31:0] m_data [WAYS][SETS];
    logic e_valid, e_hit, e_rd, e_wr, e_ex, e_c, e_allow, e_rdv;
    int e_way;
    logic [31:0] e_paddr, e_rtag, e_rdata;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model: evaluate at each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++) begin
                    m_tag[w][s] = '0;
                    m_data[w][s] = '0;
                end
            e_valid = 0; e_hit = 0; e_rd = 0; e_wr = 0; e_ex = 0; e_c = 0;
            e_allow = 0; e_way = 0; e_paddr = 0; e_rdv = 0; e_rtag = 0; e_rdata = 0;
        end else begin
            int set;
            int found;
            logic [31:0] d;
            set = int'(lk_vaddr[31:12]) % SETS;
            found = -1;
            for (int w = 0; w < WAYS; w++) begin
                logic [31:0] t;
                t = m_tag[w][set];
                if (found < 0 && t[10] && t[31:12] == lk_vaddr[31:12] &&
                    (t[11] || t[PID_W-1:0] == lk_pid))
                    found = w;
            end
            e_valid = lk_req;
            e_hit = lk_req && found >= 0;
            d = e_hit ? m_data[found][set] : 32'h0;
            e_way = e_hit ? found : 0;
            e_paddr = {d[19:0], 12'h000};
            e_rd = d[22]; e_wr = d[21]; e_ex = d[20]; e_c = d[23];
            case (lk_acc)
                2'd0: e_allow = e_hit && d[22];
                2'd1: e_allow = e_hit && d[21];
                2'd2: e_allow = e_hit && d[20];
                default: e_allow = 0;
            endcase
            e_rdv = rd_en;
            e_rtag = rd_en ? m_tag[rd_way][rd_set] : 32'h0;
            e_rdata = rd_en ? m_data[rd_way][rd_set] : 32'h0;
            if (wr_en) begin
                m_tag[wr_way][wr_set] = wr_tag;
                m_data[wr_way][wr_set] = wr_data;
            end
        end
        armed = 1;
    end

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (armed && !finished) begin
            string rq;
            rq = (phase == "R10") ? "R10" : "R9";
            chk("R1", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
            chk(phase, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
            chk("R6", "rsp_way", 32'(rsp_way), 32'(e_way));
            chk(e_hit ? "R4" : "R5", "rsp_paddr", rsp_paddr, e_paddr);
            chk(e_hit ? "R4" : "R5", "rsp_attr",
                {28'h0, rsp_c_bits()}, {28'h0, e_c, e_rd, e_wr, e_ex});
            chk("R7", "rsp_allow", 32'(rsp_allow), 32'(e_allow));
            chk(rq, "rd_valid", 32'(rd_valid), 32'(e_rdv));
            chk(rq, "rd_tag", rd_tag, e_rtag);
            chk(rq, "rd_data", rd_data, e_rdata);
        end
    end

    function automatic logic [3:0] rsp_c_bits();
        return {rsp_cache, rsp_rd, rsp_wr, rsp_ex};
    endfunction

    function automatic logic [31:0] mk_tag(int vpn, bit g, bit v, int pid);
        return {vpn[19:0], g, v, 2'b00, pid[7:0]};
    endfunction

    function automatic logic [31:0] mk_data(int pfn, bit c, bit r, bit w, bit x);
        return {8'h00, c, r, w, x, pfn[19:0]};
    endfunction

    task automatic idle();
        lk_req = 0; wr_en = 0; rd_en = 0;
        @(negedge clk);
    endtask

    task automatic put(int way, int set, logic [31:0] t, logic [31:0] d);
        wr_en = 1; wr_way = WAY_W'(way); wr_set = SET_W'(set); wr_tag = t; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(int vpn, int pid, int acc);
        lk_req = 1; lk_vaddr = {vpn[19:0], 12'hA5C}; lk_pid = PID_W'(pid); lk_acc = 2'(acc);
        @(negedge clk);
        lk_req = 0;
    endtask

    task automatic peek(int way, int set);
        rd_en = 1; rd_way = WAY_W'(way); rd_set = SET_W'(set);
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: empty table after reset, page 0 with PID 0 must miss.
        phase = "R10";
        look(0, 0, 0);
        look(32'h00013, 0, 2);
        peek(0, 0);
        peek(3, 15);
        idle();
        // R3: PID match, PID mismatch, global flag, cleared valid flag.
        phase = "R3";
        put(0, 3, mk_tag(32'h00013, 0, 1, 5), mk_data(32'hABCDE, 1, 1, 1, 0));
        look(32'h00013, 5, 0);
        look(32'h00013, 6, 0);
        put(1, 4, mk_tag(32'h00024, 1, 1, 9), mk_data(32'h12345, 0, 1, 0, 1));
        look(32'h00024, 200, 2);
        put(2, 5, mk_tag(32'h00035, 1, 0, 0), mk_data(32'h0F0F0, 1, 1, 1, 1));
        look(32'h00035, 0, 0);
        // R2: same page number low bits, different upper bits or set.
        phase = "R2";
        put(3, 7, mk_tag(32'h00107, 0, 1, 1), mk_data(32'h00777, 0, 1, 0, 0));
        look(32'h00107, 1, 0);
        look(32'h00207, 1, 0);
        look(32'h00108, 1, 0);
        // R6: identical tags in several ways, lowest wins.
        phase = "R6";
        put(3, 9, mk_tag(32'h00049, 0, 1, 2), mk_data(32'h33333, 0, 0, 1, 0));
        put(2, 9, mk_tag(32'h00049, 1, 1, 7), mk_data(32'h22222, 0, 1, 0, 0));
        look(32'h00049, 2, 1);
        put(1, 9, mk_tag(32'h00049, 0, 1, 2), mk_data(32'h11111, 1, 0, 0, 1));
        look(32'h00049, 2, 2);
        look(32'h00049, 3, 0);
        // R7: each access kind against single-permission entries.
        phase = "R7";
        for (int k = 0; k < 4; k++) look(32'h00024, 0, k);
        for (int k = 0; k < 4; k++) look(32'h00049, 7, k);
        for (int k = 0; k < 4; k++) look(32'h00049, 2, k);
        // R8: write and lookup of one entry in the same cycle.
        phase = "R8";
        lk_req = 1; lk_vaddr = 32'h0005A123; lk_pid = 8'd4; lk_acc = 2'd0;
        wr_en = 1; wr_way = 2'd0; wr_set = 4'd10;
        wr_tag = mk_tag(32'h0005A, 0, 1, 4); wr_data = mk_data(32'h5A5A5, 1, 1, 0, 0);
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        lk_req = 0;
        // R9: readback of written entries, also same-edge overwrite.
        phase = "R9";
        peek(0, 3);
        peek(2, 9);
        rd_en = 1; rd_way = 2'd0; rd_set = 4'd10;
        wr_en = 1; wr_way = 2'd0; wr_set = 4'd10; wr_tag = 32'hDEADB4C3; wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        rd_en = 0;
        // R1: idle gaps and back-to-back requests.
        phase = "R1";
        idle(); idle();
        lk_req = 1;
        for (int i = 0; i < 4; i++) begin
            lk_vaddr = {12'h000, 8'(i + 8'h13), 12'h0}; lk_pid = 8'd5;
            @(negedge clk);
        end
        lk_req = 0;
        idle();
        // Random mix of fills, lookups and readbacks over a small page range.
        phase = "R3";
        for (int i = 0; i < 3000; i++) begin
            int vpn;
            vpn = int'($urandom_range(0, 3)) * SETS + int'($urandom_range(0, SETS - 1));
            wr_en = ($urandom_range(0, 3) == 0);
            wr_way = WAY_W'($urandom); wr_set = SET_W'(vpn);
            wr_tag = mk_tag(vpn, $urandom_range(0, 3) == 0, $urandom_range(0, 4) != 0,
                            int'($urandom_range(0, 3)));
            wr_data = $urandom;
            lk_req = ($urandom_range(0, 3) != 0);
            lk_vaddr = {12'(int'($urandom_range(0, 3)) * SETS / SETS) , 20'h0} | {vpn[19:0], 12'($urandom)};
            lk_vaddr[31:12] = 20'(int'($urandom_range(0, 3)) * SETS + int'($urandom_range(0, SETS - 1)));
            lk_pid = PID_W'($urandom_range(0, 3));
            lk_acc = 2'($urandom);
            rd_en = $urandom_range(0, 1) == 1;
            rd_way = WAY_W'($urandom); rd_set = SET_W'($urandom);
            @(negedge clk);
        end
        idle(); idle();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule